// File: doc/BRIEF.md
# SPI Packet Write Sequencer

This block sends one outgoing command packet from a local transmit buffer to a peripheral. It acts as an SPI master. A requester gives a byte length and a mode bit. The block then reads the bytes from the buffer, in address order, through a byte-read port, and shifts them out. When the transfer ends it pulses a done strobe, together with an error flag and the number of bytes sent.

In normal mode the packet leaves as two separate chip-select bursts. The first burst is a fixed four-byte header. Chip select then stays high for a timed guard gap, and the second burst carries the payload. A packet of four bytes or fewer has no payload burst. In boot-loader mode the whole length goes out as one burst, with no split and no gap. A request longer than the transmit buffer capacity is refused with an overflow flag, and the SPI pins stay idle.

The SPI link runs in mode 0. The clock idles low, data is stable on the rising edge, words are 8 bits and the most significant bit goes first. The SCK half-period is derived from the system clock rate and the maximum SPI rate, so the link never runs faster than that maximum. The guard gap is derived from the system clock rate and a gap time in microseconds.

Top module: `pktwr_seq`

## Requirements
- R1: In normal mode the first chip-select burst of every accepted packet carries exactly 4 bytes, taken from buffer addresses 0 to 3.
- R2: Between the header burst and the payload burst, spi_cs_n stays high for exactly GAP_CYC = SYS_CLK_MHZ*GAP_US system clock cycles.
- R3: In normal mode a second burst is sent only when req_len > 4. It carries req_len-4 bytes from addresses 4 to req_len-1. When req_len <= 4, only the header burst is sent.
- R4: A request with req_len > MAX_LEN (default 4200) asserts err_ovf with the done pulse, reports sent_count 0 and never lowers spi_cs_n.
- R5: In boot-loader mode (req_boot=1) the block sends req_len bytes from addresses 0 onward as one single burst. When req_len is 0, no burst is sent.
- R6: done is high for exactly one cycle per accepted request. err_ovf and sent_count are valid in that cycle. For a normal request sent_count is max(req_len,4); for a boot request it is req_len.
- R7: SPI mode 0 with MSB first. spi_sck is low whenever spi_cs_n is high. Each byte is read from spi_mosi at the rising edges of spi_sck. Each high phase of spi_sck lasts HALF_DIV = ceil(SYS_CLK_MHZ/(2*SPI_MAX_MHZ)) system cycles.
- R8: A request presented while busy is high is ignored. The current packet completes unchanged, and no further done pulse follows.
- R9: After reset, spi_cs_n=1, spi_sck=0, busy=0 and done=0.
- R10: buf_rdata is expected to reflect buf_raddr in the same cycle (combinational read). Bytes are sent in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_len | input | 16 | Requested packet length in bytes |
| req_boot | input | 1 | 1 selects single-burst boot-loader mode |
| buf_raddr | output | $clog2(MAX_LEN) | Transmit buffer read address |
| buf_rdata | input | 8 | Transmit buffer byte at buf_raddr |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data out, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_ovf | output | 1 | Length overflow, valid with done |
| sent_count | output | $clog2(MAX_LEN+1) | Bytes sent, valid with done |

## Verification
Each packet is decoded from the SPI pins alone. The decoder splits the traffic into chip-select bursts, measures the high time between bursts, and checks the byte values against the buffer contents. A wrong burst-split decision therefore shows up within one packet as a wrong burst count or a wrong burst size. A wrong address counter shows up as corrupted data in the first byte affected. A stray state shows up as an extra or a missing done pulse, or as SCK activity while chip select is high. The sweep covers every length from 0 to 20 in both modes, the 4200-byte boundary on both sides, and a request arriving in mid-transfer.

// File: rtl/pktwr_pkg.sv
package pktwr_pkg;

    localparam int REQ_LEN_W = 16;
    localparam int HDR_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_GAP,
        ST_PAY,
        ST_BOOT,
        ST_FIN
    } wr_state_e;

    typedef struct packed {
        logic                 boot;
        logic [REQ_LEN_W-1:0] len;
    } wr_req_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/pktwr_spi_shift.sv
module pktwr_spi_shift #(
    parameter int HALF_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       byte_done,
    output logic       sck,
    output logic       mosi
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic             busy_q, sck_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    sh_q   <= data;
                    busy_q <= 1'b1;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign busy      = busy_q;
    assign byte_done = done_q;
    assign sck       = sck_q;
    assign mosi      = sh_q[7];

    // R7: the clock only toggles inside a byte
    assert_sck_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sck_q);

    // R7: a byte ends on a falling clock edge
    assert_done_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q && !sck_q);

endmodule

// File: rtl/pktwr_gap_timer.sv
module pktwr_gap_timer #(
    parameter int GAP_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CW'(GAP_CYC - 1);
            act_q <= 1'b1;
        end else if (act_q) begin
            if (cnt_q == '0) act_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = act_q && (cnt_q == '0);

    // R2: expiry ends the gap run
    assert_gap_once_R2: assert property (@(posedge clk) disable iff (rst)
        expired && !load |=> !expired);

endmodule

// File: rtl/pktwr_seq.sv
module pktwr_seq
    import pktwr_pkg::*;
#(
    parameter int MAX_LEN     = 4200,
    parameter int SYS_CLK_MHZ = 250,
    parameter int SPI_MAX_MHZ = 16,
    parameter int GAP_US      = 40,
    localparam int ADDR_W     = $clog2(MAX_LEN),
    localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [REQ_LEN_W-1:0] req_len,
    input  logic                 req_boot,
    output logic [ADDR_W-1:0]    buf_raddr,
    input  logic [7:0]           buf_rdata,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    output logic                 spi_cs_n,
    output logic                 busy,
    output logic                 done,
    output logic                 err_ovf,
    output logic [CNT_W-1:0]     sent_count
);
    localparam int HALF_DIV = ceil_div(SYS_CLK_MHZ, 2 * SPI_MAX_MHZ);
    localparam int GAP_CYC  = SYS_CLK_MHZ * GAP_US;
    localparam logic [CNT_W-1:0] HDR_N = CNT_W'(HDR_BYTES);

    wr_state_e         state_q;
    wr_req_t           req;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q, pay_q, cnt_q, len_n;
    logic              err_q;
    logic              in_burst, sh_busy, sh_done, sh_start, burst_end;
    logic              gap_load, gap_exp;

    assign req       = '{boot: req_boot, len: req_len};
    assign len_n     = req.len[CNT_W-1:0];
    assign in_burst  = (state_q == ST_HDR) || (state_q == ST_PAY) || (state_q == ST_BOOT);
    assign sh_start  = in_burst && !sh_busy && (left_q != '0);
    assign burst_end = in_burst && !sh_busy && (left_q == '0);
    assign gap_load  = (state_q == ST_HDR) && burst_end && (pay_q != '0);

    pktwr_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .data      (buf_rdata),
        .busy      (sh_busy),
        .byte_done (sh_done),
        .sck       (spi_sck),
        .mosi      (spi_mosi)
    );

    pktwr_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            pay_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= '0;
                        if (req.len > REQ_LEN_W'(MAX_LEN)) begin
                            err_q   <= 1'b1;
                            cnt_q   <= '0;
                            state_q <= ST_FIN;
                        end else if (req.boot) begin
                            err_q   <= 1'b0;
                            left_q  <= len_n;
                            pay_q   <= '0;
                            cnt_q   <= len_n;
                            state_q <= (len_n == '0) ? ST_FIN : ST_BOOT;
                        end else begin
                            err_q   <= 1'b0;
                            left_q  <= HDR_N;
                            pay_q   <= (len_n > HDR_N) ? (len_n - HDR_N) : '0;
                            cnt_q   <= (len_n > HDR_N) ? len_n : HDR_N;
                            state_q <= ST_HDR;
                        end
                    end
                end
                ST_HDR, ST_PAY, ST_BOOT: begin
                    if (sh_start) begin
                        addr_q <= addr_q + ADDR_W'(1);
                        left_q <= left_q - CNT_W'(1);
                    end
                    if (burst_end) begin
                        if (gap_load) begin
                            left_q  <= pay_q;
                            state_q <= ST_GAP;
                        end else begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_exp) state_q <= ST_PAY;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign buf_raddr  = addr_q;
    assign spi_cs_n   = !in_burst;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FIN);
    assign err_ovf    = err_q;
    assign sent_count = cnt_q;

    // R6: completion is a single-cycle strobe
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: an oversize request goes straight to completion with the link idle
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) && req_valid && (req_len > REQ_LEN_W'(MAX_LEN))
        |=> done && err_ovf && spi_cs_n);

    // R8: requests seen while busy leave the latched result untouched
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy && req_valid |=> $stable(cnt_q) && $stable(err_q));

    // R2: chip select is high and the clock idle through the guard gap
    assert_gap_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |-> spi_cs_n && !spi_sck);

    // R7: no clock activity while chip select is high
    assert_cs_sck_R7: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

endmodule

// File: tb/pktwr_seq_tb.sv
module pktwr_seq_tb;
    localparam int MAX_LEN = 4200;
    localparam int SYS_MHZ = 32;
    localparam int SPI_MHZ = 16;
    localparam int GAP_US  = 1;
    localparam int GAP_CYC = SYS_MHZ * GAP_US;
    localparam int HALF    = (SYS_MHZ + 2 * SPI_MHZ - 1) / (2 * SPI_MHZ);
    localparam int AW      = $clog2(MAX_LEN);
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [15:0]   req_len = '0;
    logic          req_boot = 1'b0;
    logic [AW-1:0] buf_raddr;
    logic [7:0]    buf_rdata;
    logic          spi_sck, spi_mosi, spi_cs_n, busy, done, err_ovf;
    logic [CW-1:0] sent_count;

    logic [7:0] mem [0:MAX_LEN-1];
    assign buf_rdata = mem[buf_raddr];

    always #2 clk = ~clk;

    pktwr_seq #(.MAX_LEN(MAX_LEN), .SYS_CLK_MHZ(SYS_MHZ),
                .SPI_MAX_MHZ(SPI_MHZ), .GAP_US(GAP_US)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
        .req_boot(req_boot), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .busy(busy), .done(done), .err_ovf(err_ovf), .sent_count(sent_count)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // SPI decoder state
    logic       mon_clr = 1'b0;
    logic       p_sck = 1'b0, p_cs = 1'b1;
    logic [7:0] sh = '0;
    int         bitc = 0, nbytes = 0, nburst = 0, hi_run = 0, cs_hi = 0;
    int         gap_len = -1, sck_bad = 0, idle_bad = 0, ndone = 0;
    int         bsz [0:3];
    logic [7:0] got [0:MAX_LEN+15];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            nbytes = 0; nburst = 0; bitc = 0; gap_len = -1;
            sck_bad = 0; idle_bad = 0; ndone = 0; cs_hi = 0;
            for (int i = 0; i < 4; i++) bsz[i] = 0;
        end else if (!rst) begin
            if (done) ndone++;
            if (spi_cs_n && spi_sck) idle_bad++;
            if (spi_sck) hi_run++;
            if (!spi_sck && p_sck) begin
                if (hi_run != HALF) sck_bad++;
                hi_run = 0;
            end
            if (!spi_cs_n && p_cs) begin
                if (nburst >= 1) gap_len = cs_hi;
                nburst++;
                bitc = 0;
            end
            if (spi_cs_n && !p_cs && bitc != 0) sck_bad++;
            if (spi_cs_n) cs_hi++; else cs_hi = 0;
            if (spi_sck && !p_sck && !spi_cs_n) begin
                sh = {sh[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    if (nbytes < MAX_LEN + 16) got[nbytes] = sh;
                    nbytes++;
                    if (nburst >= 1 && nburst <= 4) bsz[nburst-1]++;
                    bitc = 0;
                end
            end
        end
        p_sck = spi_sck;
        p_cs  = spi_cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int len, input bit boot);
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr   = 1'b0;
        req_valid = 1'b1;
        req_len   = 16'(len);
        req_boot  = boot;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish(input int len, input bit boot);
        int  w = 0;
        int  exp_cnt, exp_b0, exp_b1, exp_nb, bad;
        bit  ovf;
        while (!done && w < 150000) begin
            @(negedge clk);
            w++;
        end
        ovf     = (len > MAX_LEN);
        exp_cnt = ovf ? 0 : (boot ? len : ((len > 4) ? len : 4));
        exp_nb  = ovf ? 0 : (boot ? ((len > 0) ? 1 : 0) : ((len > 4) ? 2 : 1));
        exp_b0  = ovf ? 0 : (boot ? len : 4);
        exp_b1  = (!ovf && !boot && len > 4) ? len - 4 : 0;
        chk(done == 1'b1, "R6 done seen", int'(done), 1);
        chk(err_ovf == ovf, "R4 overflow flag", int'(err_ovf), int'(ovf));
        chk(int'(sent_count) == exp_cnt, "R6 sent_count", int'(sent_count), exp_cnt);
        repeat (4) @(negedge clk);
        chk(ndone == 1, "R6 one done pulse", ndone, 1);
        if (boot) chk(nburst == exp_nb, "R5 burst count", nburst, exp_nb);
        else if (ovf) chk(nburst == 0, "R4 no burst on overflow", nburst, 0);
        else chk(nburst == exp_nb, "R3 burst count", nburst, exp_nb);
        if (exp_nb >= 1) begin
            if (boot) chk(bsz[0] == exp_b0, "R5 burst size", bsz[0], exp_b0);
            else      chk(bsz[0] == exp_b0, "R1 header size", bsz[0], exp_b0);
        end
        if (exp_nb == 2) begin
            chk(bsz[1] == exp_b1, "R3 payload size", bsz[1], exp_b1);
            chk(gap_len == GAP_CYC, "R2 gap cycles", gap_len, GAP_CYC);
        end
        bad = 0;
        for (int i = 0; i < exp_cnt && i < nbytes; i++)
            if (got[i] !== mem[i]) bad++;
        chk(bad == 0 && nbytes == exp_cnt, "R10 R7 byte data MSB first", nbytes - bad, exp_cnt);
        chk(sck_bad == 0 && idle_bad == 0, "R7 sck timing", sck_bad + idle_bad, 0);
        chk(!busy, "R8 idle after packet", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
        for (int i = 0; i < 4; i++) bsz[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(spi_cs_n == 1'b1, "R9 cs_n after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R9 sck after reset", int'(spi_sck), 0);
        chk(busy == 1'b0 && done == 1'b0, "R9 busy/done after reset", int'(busy) + int'(done), 0);

        for (int l = 0; l <= 20; l++) begin issue(l, 1'b0); finish(l, 1'b0); end
        for (int l = 0; l <= 20; l++) begin issue(l, 1'b1); finish(l, 1'b1); end
        issue(4201, 1'b0);  finish(4201, 1'b0);
        issue(4201, 1'b1);  finish(4201, 1'b1);
        issue(65535, 1'b0); finish(65535, 1'b0);
        issue(300, 1'b1);   finish(300, 1'b1);
        issue(4200, 1'b0);  finish(4200, 1'b0);

        // R8: a request in mid-transfer is ignored
        issue(12, 1'b0);
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_len = 16'd3; req_boot = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        finish(12, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule